// File: doc/BRIEF.md
# Eight-Line GPIO Register Bank with Selectable Register Map

This block is a small general-purpose I/O peripheral with eight lines, reached through a byte-wide register bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. Every register holds one bit per line. The block drives a pad output value and a per-line output enable. It brings the pad levels into the clock domain through a two-stage synchronizer before software can read them.

A static parameter picks one of three register maps when the block is built:

- The bidirectional map has three registers. The line-mode register is at 0x00, the drive-value register at 0x01 and the sampled-level register at 0x02.
- The sense-only map has a single sampled-level register at 0x00.
- The drive-only map has a single drive-value register at 0x00, and every line is always driven.

Software changes one bit of a register by reading the register, clearing and setting the chosen bits, and writing the result back. The other bits keep their values.

Top module: `gpio_bank`

## Requirements
- R1: Bidirectional map. A write to 0x00 loads the line-mode register and a write to 0x01 loads the drive-value register. A read of either offset returns the stored byte. Bit n of each register belongs to line n.
- R2: Bidirectional map. pad_oe[n] is 1 exactly when line-mode bit n is 1 (output) and 0 when it is 0 (input). pad_out always equals the drive-value register.
- R3: A pad level present on pad_in at clock edge k is returned by a read of the sampled-level register issued at edge k+2 or later. A read issued earlier returns the older synchronized level. In the bidirectional map this register is at 0x02.
- R4: Sense-only map. A read of 0x00 returns the synchronized pad levels. Writes to any offset have no effect. pad_oe and pad_out stay 0x00.
- R5: Drive-only map. A write to 0x00 loads the drive-value register, which appears on pad_out. A read of 0x00 returns the latched value. pad_oe is 0xFF at all times, including during reset.
- R6: In every map, a write to an offset the map does not define changes no register, and a read of such an offset returns 0x00.
- R7: While rst_n is sampled low, the line-mode register, the drive-value register, the synchronizer stages and bus_rdata all clear to 0x00. In the bidirectional and sense-only maps pad_oe is therefore 0x00.
- R8: bus_rdata is loaded on the edge where bus_rd is 1 and holds its value while bus_rd is 0. When a read and a write hit the same register in the same cycle, the read returns the value from before the write.
- R9: A read, then a write of that value with chosen bits cleared and chosen bits set, changes only those bits and leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| pad_in | input | 8 | Pad levels, asynchronous to clk |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The bench builds three instances side by side, one with FLAVOR set to each of the bidirectional, sense-only and drive-only maps. All three share the same bus and pad stimulus. The same write to offset 0x00 therefore lands in the line-mode register of one instance, is ignored by the second and sets the drive value of the third. This puts the offset shift between maps and the write-ignore rule of the sense-only map under direct comparison in the same cycles. Pad changes timed against back-to-back reads expose the two-cycle synchronizer latency in both maps that have a sampled-level register.

// File: rtl/gpio_bank_pkg.sv
// Shared types and offset functions for the GPIO register bank.
// Assumes: offsets fit in the bus address width chosen by the top.
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        FLV_BIDIR    = 2'd0,
        FLV_IN_ONLY  = 2'd1,
        FLV_OUT_ONLY = 2'd2
    } flavor_e;

    // Offset of the line-mode register (bidirectional map only).
    function automatic int unsigned mode_offset(flavor_e f);
        return (f == FLV_BIDIR) ? 0 : 0;
    endfunction

    // Offset of the drive-value register.
    function automatic int unsigned drive_offset(flavor_e f);
        return (f == FLV_BIDIR) ? 1 : 0;
    endfunction

    // Offset of the sampled-level register.
    function automatic int unsigned sense_offset(flavor_e f);
        return (f == FLV_BIDIR) ? 2 : 0;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Two-stage synchronizer for the pad levels.
// Assumes: each pad is a slow level, so per-bit sync is enough.
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> stage2_q == $past(stage1_q)); // R3

endmodule

// File: rtl/gpio_store.sv
// Holds the writable registers (line mode, drive value) for one map.
// Assumes: one write strobe per cycle. A register the map lacks reads as
// zero and ignores writes.
module gpio_store #(
    parameter int WIDTH    = 8,
    parameter int ADDR_W   = 8,
    parameter bit HAS_MODE = 1'b1,
    parameter bit HAS_DRV  = 1'b1,
    parameter int MODE_OFF = 0,
    parameter int DRV_OFF  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_wr,
    output logic [WIDTH-1:0]  mode_q,
    output logic [WIDTH-1:0]  drv_q
);

    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFF);
    localparam logic [ADDR_W-1:0] DRV_A  = ADDR_W'(DRV_OFF);

    generate
        if (HAS_MODE) begin : g_mode
            // Load the line-mode register on a decoded write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mode_q <= '0;
                else if (bus_wr && bus_addr == MODE_A)
                    mode_q <= bus_wdata;
            end

            AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == MODE_A) |=> mode_q == $past(bus_wdata)); // R1
            AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                !(bus_wr && bus_addr == MODE_A) |=> $stable(mode_q)); // R6
        end else begin : g_no_mode
            assign mode_q = '0;
        end

        if (HAS_DRV) begin : g_drv
            // Load the drive-value register on a decoded write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    drv_q <= '0;
                else if (bus_wr && bus_addr == DRV_A)
                    drv_q <= bus_wdata;
            end

            AST_DRV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == DRV_A) |=> drv_q == $past(bus_wdata)); // R5
            AST_DRV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                !(bus_wr && bus_addr == DRV_A) |=> $stable(drv_q)); // R6
        end else begin : g_no_drv
            assign drv_q = '0;
        end
    endgenerate

endmodule

// File: rtl/gpio_readmux.sv
// Decodes a read and registers the selected byte onto bus_rdata.
// Assumes: undefined offsets read as zero; data holds between reads.
module gpio_readmux #(
    parameter int WIDTH     = 8,
    parameter int ADDR_W    = 8,
    parameter bit HAS_MODE  = 1'b1,
    parameter bit HAS_DRV   = 1'b1,
    parameter bit HAS_SENSE = 1'b1,
    parameter int MODE_OFF  = 0,
    parameter int DRV_OFF   = 1,
    parameter int SENSE_OFF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  mode_q,
    input  logic [WIDTH-1:0]  drv_q,
    input  logic [WIDTH-1:0]  sense_q,
    output logic [WIDTH-1:0]  bus_rdata
);

    localparam logic [ADDR_W-1:0] MODE_A  = ADDR_W'(MODE_OFF);
    localparam logic [ADDR_W-1:0] DRV_A   = ADDR_W'(DRV_OFF);
    localparam logic [ADDR_W-1:0] SENSE_A = ADDR_W'(SENSE_OFF);

    logic [WIDTH-1:0] sel_data;
    logic             hit;

    // Pick the byte addressed by the current offset.
    always_comb begin
        sel_data = '0;
        hit      = 1'b0;
        if (HAS_MODE && bus_addr == MODE_A) begin
            sel_data = mode_q;
            hit      = 1'b1;
        end else if (HAS_DRV && bus_addr == DRV_A) begin
            sel_data = drv_q;
            hit      = 1'b1;
        end else if (HAS_SENSE && bus_addr == SENSE_A) begin
            sel_data = sense_q;
            hit      = 1'b1;
        end
    end

    // Capture read data on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= sel_data;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R8
    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |=> bus_rdata == '0); // R6

    generate
        if (HAS_SENSE) begin : g_sense_chk
            AST_SENSE_READ: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_rd && bus_addr == SENSE_A) |=> bus_rdata == $past(sense_q)); // R3
        end
    endgenerate

endmodule

// File: rtl/gpio_bank.sv
// Eight-line GPIO register bank with a build-time choice of register map:
// bidirectional, sense-only or drive-only.
// Assumes: single-cycle bus strobes; pad_in is asynchronous to clk.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int      LINES  = 8,
    parameter int      ADDR_W = 8,
    parameter flavor_e FLAVOR = FLV_BIDIR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe
);

    localparam bit HAS_MODE  = (FLAVOR == FLV_BIDIR);
    localparam bit HAS_DRV   = (FLAVOR != FLV_IN_ONLY);
    localparam bit HAS_SENSE = (FLAVOR != FLV_OUT_ONLY);
    localparam int MODE_OFF  = int'(mode_offset(FLAVOR));
    localparam int DRV_OFF   = int'(drive_offset(FLAVOR));
    localparam int SENSE_OFF = int'(sense_offset(FLAVOR));

    logic [LINES-1:0] mode_q;
    logic [LINES-1:0] drv_q;
    logic [LINES-1:0] sense_q;

    gpio_sync #(.WIDTH(LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sense_q)
    );

    gpio_store #(
        .WIDTH    (LINES),
        .ADDR_W   (ADDR_W),
        .HAS_MODE (HAS_MODE),
        .HAS_DRV  (HAS_DRV),
        .MODE_OFF (MODE_OFF),
        .DRV_OFF  (DRV_OFF)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .mode_q    (mode_q),
        .drv_q     (drv_q)
    );

    gpio_readmux #(
        .WIDTH     (LINES),
        .ADDR_W    (ADDR_W),
        .HAS_MODE  (HAS_MODE),
        .HAS_DRV   (HAS_DRV),
        .HAS_SENSE (HAS_SENSE),
        .MODE_OFF  (MODE_OFF),
        .DRV_OFF   (DRV_OFF),
        .SENSE_OFF (SENSE_OFF)
    ) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .mode_q    (mode_q),
        .drv_q     (drv_q),
        .sense_q   (sense_q),
        .bus_rdata (bus_rdata)
    );

    assign pad_out = drv_q;

    // Pick the output-enable source for the chosen map.
    generate
        if (FLAVOR == FLV_OUT_ONLY) begin : g_oe_all
            assign pad_oe = '1;
        end else begin : g_oe_mode
            assign pad_oe = mode_q;
        end
    endgenerate

    generate
        if (FLAVOR == FLV_IN_ONLY) begin : g_in_chk
            AST_IN_ONLY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
                bus_wr |=> (pad_oe == '0 && pad_out == '0)); // R4
        end
    endgenerate

endmodule

// File: tb/sim_gpio_bank.sv
// Bench: three map variants driven by shared stimulus, each compared every
// clock against a behavioural model of the requirements.
module sim_gpio_bank;
    import gpio_bank_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] rd0, rd1, rd2, po0, po1, po2, oe0, oe1, oe2;

    always #4 clk = ~clk; // 125 MHz

    gpio_bank #(.FLAVOR(FLV_BIDIR)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rd0),
        .pad_in(pad_in), .pad_out(po0), .pad_oe(oe0));
    gpio_bank #(.FLAVOR(FLV_IN_ONLY)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rd1),
        .pad_in(pad_in), .pad_out(po1), .pad_oe(oe1));
    gpio_bank #(.FLAVOR(FLV_OUT_ONLY)) u2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rd2),
        .pad_in(pad_in), .pad_out(po2), .pad_oe(oe2));

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    bit    chk_en = 1'b0;
    string cur_req = "R7";

    // Reference model state
    logic [7:0] m_mode, m_drv0, m_drv2, m_s1, m_s2, m_rd0, m_rd1, m_rd2;

    // Model update from the requirements at every edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_drv0 = 0; m_drv2 = 0; m_s1 = 0; m_s2 = 0;
            m_rd0 = 0; m_rd1 = 0; m_rd2 = 0;
        end else begin
            if (bus_rd) begin
                case (bus_addr)
                    8'h00:   m_rd0 = m_mode;
                    8'h01:   m_rd0 = m_drv0;
                    8'h02:   m_rd0 = m_s2;
                    default: m_rd0 = 0;
                endcase
                m_rd1 = (bus_addr == 8'h00) ? m_s2 : 8'h00;
                m_rd2 = (bus_addr == 8'h00) ? m_drv2 : 8'h00;
            end
            if (bus_wr) begin
                if (bus_addr == 8'h00) begin m_mode = bus_wdata; m_drv2 = bus_wdata; end
                if (bus_addr == 8'h01) m_drv0 = bus_wdata;
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    task automatic cmp(input string what, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare all outputs shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (chk_en) begin
            cmp("u0.rdata", rd0, m_rd0);
            cmp("u0.pad_out", po0, m_drv0);
            cmp("u0.pad_oe", oe0, m_mode);
            cmp("u1.rdata", rd1, m_rd1);
            cmp("u1.pad_out", po1, 8'h00);
            cmp("u1.pad_oe", oe1, 8'h00);
            cmp("u2.rdata", rd2, m_rd2);
            cmp("u2.pad_out", po2, m_drv2);
            cmp("u2.pad_oe", oe2, 8'hFF);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic bus(input logic wr, input logic rd, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    logic [7:0] got;

    initial begin
        // R7: reset state
        idle(1);
        chk_en = 1'b1;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        bus(1'b0, 1'b1, 8'h00, 8'h00);
        bus(1'b0, 1'b1, 8'h01, 8'h00);

        // R1: write and read back the mode and drive registers
        cur_req = "R1";
        bus(1'b1, 1'b0, 8'h00, 8'h5A);
        bus(1'b1, 1'b0, 8'h01, 8'hC3);
        bus(1'b0, 1'b1, 8'h00, 8'h00);
        bus(1'b0, 1'b1, 8'h01, 8'h00);

        // R2: output enable follows the mode bits
        cur_req = "R2";
        bus(1'b1, 1'b0, 8'h00, 8'hF0);
        bus(1'b1, 1'b0, 8'h01, 8'h0F);
        bus(1'b1, 1'b0, 8'h00, 8'h01);
        idle(2);

        // R3: synchronizer latency, back-to-back reads across a pad change
        cur_req = "R3";
        @(negedge clk); pad_in = 8'h3C; bus_rd = 1'b1; bus_addr = 8'h02;
        bus(1'b0, 1'b1, 8'h02, 8'h00);
        bus(1'b0, 1'b1, 8'h02, 8'h00);
        bus(1'b0, 1'b1, 8'h02, 8'h00);
        @(negedge clk); pad_in = 8'hA5; bus_addr = 8'h00;
        bus(1'b0, 1'b1, 8'h00, 8'h00);
        bus(1'b0, 1'b1, 8'h00, 8'h00);
        bus(1'b0, 1'b1, 8'h00, 8'h00);

        // R4: sense-only map ignores writes
        cur_req = "R4";
        bus(1'b1, 1'b0, 8'h00, 8'hFF);
        bus(1'b1, 1'b0, 8'h02, 8'h77);
        bus(1'b0, 1'b1, 8'h00, 8'h00);
        idle(1);

        // R5: drive-only map
        cur_req = "R5";
        bus(1'b1, 1'b0, 8'h00, 8'h96);
        bus(1'b0, 1'b1, 8'h00, 8'h00);
        bus(1'b1, 1'b0, 8'h00, 8'h00);
        bus(1'b0, 1'b1, 8'h00, 8'h00);

        // R6: undefined offsets
        cur_req = "R6";
        bus(1'b1, 1'b0, 8'h01, 8'h33);
        bus(1'b1, 1'b0, 8'h03, 8'hEE);
        bus(1'b1, 1'b0, 8'hFF, 8'hEE);
        bus(1'b1, 1'b0, 8'h10, 8'hEE);
        bus(1'b0, 1'b1, 8'h03, 8'h00);
        bus(1'b0, 1'b1, 8'h01, 8'h00);
        bus(1'b0, 1'b1, 8'hFF, 8'h00);
        bus(1'b0, 1'b1, 8'h02, 8'h00);
        bus(1'b0, 1'b1, 8'h80, 8'h00);

        // R8: read data hold and read-during-write
        cur_req = "R8";
        bus(1'b0, 1'b1, 8'h01, 8'h00);
        idle(3);
        bus(1'b1, 1'b1, 8'h01, 8'h44);
        bus(1'b1, 1'b1, 8'h00, 8'h81);
        idle(2);
        bus(1'b0, 1'b1, 8'h01, 8'h00);

        // R9: read-modify-write of single bits
        cur_req = "R9";
        for (int k = 0; k < 4; k++) begin
            bus(1'b0, 1'b1, 8'h01, 8'h00);
            idle(1);
            got = rd0;
            bus(1'b1, 1'b0, 8'h01, (got & ~(8'h01 << k)) | (8'h10 << k));
            bus(1'b0, 1'b1, 8'h01, 8'h00);
        end

        // Mixed traffic
        cur_req = "R1";
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            pad_in    = 8'((i * 37) ^ (i >> 2));
            bus_wr    = (i % 3) == 0;
            bus_rd    = (i % 2) == 1;
            bus_addr  = 8'(i % 5);
            bus_wdata = 8'(i * 73 + 11);
        end
        idle(4);

        // R7: reset again mid-operation
        cur_req = "R7";
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        chk_en = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule